// File: doc/BRIEF.md
# Bit-Serial Page Write Sequencer

This block is the host side of a page write to a memory that is reached one data bit per bus cycle over chip-enable, output-enable and write-enable strobes and a single bidirectional I/O line. A request carries a start address, a byte count and, over a valid/ready stream, the bytes themselves. The block arms the memory with a reset pulse, shifts out the address and the data one bit per write cycle, closes the load with a three-cycle commit and then reads the I/O line until the memory reports that its internal write has finished.

Every bus cycle is a low strobe window of a fixed number of clocks followed by an idle gap with chip enable high. The protocol itself has no timing limits, so the gap length is free. A request whose byte count is zero or larger than a page is refused at once with an error pulse and produces no bus activity. A memory that never finishes is abandoned after a bounded number of status reads, with a timeout pulse.

Back-pressure on the byte stream: `wr_ready_o` is high only while the sequencer waits for the next byte. A byte moves on a clock edge where `wr_valid_i` and `wr_ready_o` are both high. The source may hold `wr_valid_i` high early, and the sequencer may hold the bus idle for any number of clocks while no byte is offered.

Top module: `bsw_page_writer`

## Requirements
- R1: In a write cycle `mem_ce_n_o` and `mem_we_n_o` are low, `mem_oe_n_o` is high, `mem_io_oe_o` is 1 and `mem_io_o` stays stable. In a read cycle `mem_ce_n_o` and `mem_oe_n_o` are low, `mem_we_n_o` is high and `mem_io_oe_o` is 0. The write and output strobes are never low together.
- R2: Every strobe window, including the reset pulse, lasts exactly STROBE_W clocks. Between two windows the strobes stay inactive for at least GAP_W clocks.
- R3: An accepted request begins with one reset pulse on `mem_rst_o`, with `mem_ce_n_o` high. Sixteen write cycles follow that carry the address, most significant bit first.
- R4: The data follows as 8 write cycles per byte, bit 7 first, with no read cycle anywhere between the first address bit and the commit. A byte transfers only on an edge with valid and ready both high, and ready is never high while the block is idle.
- R5: After the last data bit the block issues a read cycle, then a write cycle with I/O value 1, then a read cycle. These are the commit.
- R6: After the commit the block repeats read cycles. On the first read that samples `mem_io_i` high it raises `done_o` for one clock and drops `busy_o` in the same clock.
- R7: If MAX_POLLS status reads all sample low, the block raises `err_tmo_o` for one clock instead of `done_o` and returns to idle.
- R8: A start with a byte count of 0 or above MAX_BYTES (32) raises `err_len_o` for one clock in the next cycle, leaves `busy_o` low and issues no bus cycle.
- R9: A start while busy is ignored. The running sequence carries on unchanged.
- R10: During and right after reset all three strobes are high, `mem_rst_o` is low, and `busy_o` and `wr_ready_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, accepted while idle |
| addr_i | input | 16 | Start address of the page write |
| len_i | input | 6 | Number of bytes, 1 to 32 |
| wr_valid_i | input | 1 | Byte stream valid |
| wr_data_i | input | 8 | Byte stream data |
| wr_ready_o | output | 1 | Byte stream ready |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-clock pulse on successful completion |
| err_len_o | output | 1 | One-clock pulse on a rejected byte count |
| err_tmo_o | output | 1 | One-clock pulse on status poll timeout |
| mem_rst_o | output | 1 | Memory reset pulse |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_io_o | output | 1 | I/O line drive value |
| mem_io_oe_o | output | 1 | I/O line drive enable |
| mem_io_i | input | 1 | I/O line sampled value |

## Verification
The hardest case to reach is the status poll. Commit reads and poll reads look alike on the bus, and the block must ignore the line during the commit but act on it during polling. The poll budget must also end in the right cycle. The bench's memory model counts the read cycles it has seen in each request and holds the I/O line low for a chosen number of poll reads, including zero and counts at and past the timeout limit. That puts the first high sample on an exact poll, or on none at all. A second start is also injected while each request is running, to show that it leaves the recorded bus trace untouched.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_RD  = 2'd1,
    OP_RST = 2'd2
  } bus_op_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RST,
    SQ_ADDR,
    SQ_LOAD,
    SQ_DATA,
    SQ_CMT,
    SQ_POLL
  } seq_st_e;
endpackage

// File: rtl/bsw_bus_cycle.sv
module bsw_bus_cycle
  import bsw_pkg::*;
#(
  parameter int STROBE_W = 2,
  parameter int GAP_W    = 1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    go_i,
  input  bus_op_e op_i,
  input  logic    bit_i,
  output logic    idle_o,
  output logic    done_o,
  output logic    rbit_o,
  output logic    ce_n_o,
  output logic    oe_n_o,
  output logic    we_n_o,
  output logic    io_o,
  output logic    io_oe_o,
  output logic    pulse_o,
  input  logic    io_i
);
  localparam int MAXW = (STROBE_W > GAP_W) ? STROBE_W : GAP_W;
  localparam int CW   = $clog2(MAXW + 1);

  typedef enum logic [1:0] {BC_IDLE, BC_LOW, BC_GAP} bc_st_e;

  bc_st_e          st;
  logic [CW-1:0]   cnt;
  bus_op_e         op_q;
  logic            bit_q;
  logic            rbit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= BC_IDLE;
      cnt    <= '0;
      op_q   <= OP_WR;
      bit_q  <= 1'b0;
      rbit_q <= 1'b0;
    end else begin
      case (st)
        BC_IDLE: if (go_i) begin
          st    <= BC_LOW;
          cnt   <= CW'(STROBE_W - 1);
          op_q  <= op_i;
          bit_q <= bit_i;
        end
        BC_LOW: if (cnt == '0) begin
          st  <= BC_GAP;
          cnt <= CW'(GAP_W - 1);
          if (op_q == OP_RD) rbit_q <= io_i;
        end else begin
          cnt <= cnt - 1'b1;
        end
        BC_GAP: if (cnt == '0) st <= BC_IDLE;
                else cnt <= cnt - 1'b1;
        default: st <= BC_IDLE;
      endcase
    end
  end

  logic low;
  assign low     = (st == BC_LOW);
  assign ce_n_o  = !(low && op_q != OP_RST);
  assign we_n_o  = !(low && op_q == OP_WR);
  assign oe_n_o  = !(low && op_q == OP_RD);
  assign io_oe_o = low && op_q == OP_WR;
  assign io_o    = io_oe_o ? bit_q : 1'b0;
  assign pulse_o = low && op_q == OP_RST;
  assign idle_o  = (st == BC_IDLE);
  assign done_o  = (st == BC_GAP) && (cnt == '0);
  assign rbit_o  = rbit_q;

  // checker: length of every active window, counted independently of cnt
  logic [7:0] act_len;
  logic       active;
  assign active = !ce_n_o || pulse_o;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_len <= '0;
    else if (active) act_len <= act_len + 1'b1;
    else act_len <= '0;
  end

  AST_STROBE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(active) |-> act_len == 8'(STROBE_W))); // R2
  AST_RST_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o |-> ce_n_o && we_n_o && oe_n_o)); // R3
  AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i |-> idle_o)); // R2
endmodule

// File: rtl/bsw_frame_seq.sv
module bsw_frame_seq
  import bsw_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 6,
  parameter int MAX_BYTES = 32,
  parameter int MAX_POLLS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              wvalid_i,
  input  logic [7:0]        wdata_i,
  output logic              wready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_len_o,
  output logic              err_tmo_o,
  output logic              go_o,
  output bus_op_e           op_o,
  output logic              bit_o,
  input  logic              eng_idle_i,
  input  logic              eng_done_i,
  input  logic              eng_rbit_i
);
  localparam int BIT_CW = $clog2(ADDR_W);
  localparam int PC_W   = $clog2(MAX_POLLS + 1);

  seq_st_e           st;
  logic [ADDR_W-1:0] sh;
  logic [BIT_CW-1:0] bitc;
  logic [LEN_W-1:0]  left;
  logic [1:0]        cidx;
  logic [PC_W-1:0]   polls;
  logic              issued;
  logic              done_q, elen_q, etmo_q;

  logic len_ok, cycling;
  assign len_ok  = (len_i != '0) && (len_i <= LEN_W'(MAX_BYTES));
  assign cycling = (st == SQ_RST) || (st == SQ_ADDR) || (st == SQ_DATA) ||
                   (st == SQ_CMT) || (st == SQ_POLL);
  assign go_o    = cycling && !issued && eng_idle_i;

  always_comb begin
    op_o  = OP_WR;
    bit_o = 1'b0;
    case (st)
      SQ_RST:  op_o = OP_RST;
      SQ_ADDR, SQ_DATA: begin
        op_o  = OP_WR;
        bit_o = sh[ADDR_W-1];
      end
      SQ_CMT: begin
        op_o  = (cidx == 2'd1) ? OP_WR : OP_RD;
        bit_o = 1'b1;
      end
      SQ_POLL: op_o = OP_RD;
      default: op_o = OP_WR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SQ_IDLE;
      sh     <= '0;
      bitc   <= '0;
      left   <= '0;
      cidx   <= '0;
      polls  <= '0;
      issued <= 1'b0;
      done_q <= 1'b0;
      elen_q <= 1'b0;
      etmo_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      elen_q <= 1'b0;
      etmo_q <= 1'b0;
      if (go_o) issued <= 1'b1;
      else if (eng_done_i) issued <= 1'b0;
      case (st)
        SQ_IDLE: if (start_i) begin
          if (len_ok) begin
            st   <= SQ_RST;
            sh   <= addr_i;
            left <= len_i;
          end else begin
            elen_q <= 1'b1;
          end
        end
        SQ_RST: if (eng_done_i) begin
          st   <= SQ_ADDR;
          bitc <= BIT_CW'(ADDR_W - 1);
        end
        SQ_ADDR: if (eng_done_i) begin
          sh <= sh << 1;
          if (bitc == '0) st <= SQ_LOAD;
          else bitc <= bitc - 1'b1;
        end
        SQ_LOAD: if (wvalid_i) begin
          sh[ADDR_W-1 -: 8] <= wdata_i;
          bitc <= BIT_CW'(7);
          st   <= SQ_DATA;
        end
        SQ_DATA: if (eng_done_i) begin
          sh <= sh << 1;
          if (bitc == '0) begin
            if (left == LEN_W'(1)) begin
              st   <= SQ_CMT;
              cidx <= '0;
            end else begin
              left <= left - 1'b1;
              st   <= SQ_LOAD;
            end
          end else begin
            bitc <= bitc - 1'b1;
          end
        end
        SQ_CMT: if (eng_done_i) begin
          if (cidx == 2'd2) begin
            st    <= SQ_POLL;
            polls <= '0;
          end else begin
            cidx <= cidx + 1'b1;
          end
        end
        SQ_POLL: if (eng_done_i) begin
          if (eng_rbit_i) begin
            st     <= SQ_IDLE;
            done_q <= 1'b1;
          end else if (polls == PC_W'(MAX_POLLS - 1)) begin
            st     <= SQ_IDLE;
            etmo_q <= 1'b1;
          end else begin
            polls <= polls + 1'b1;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign wready_o  = (st == SQ_LOAD);
  assign busy_o    = (st != SQ_IDLE);
  assign done_o    = done_q;
  assign err_len_o = elen_q;
  assign err_tmo_o = etmo_q;

  AST_READY_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wready_o |-> busy_o)); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o |-> !busy_o)); // R6
  AST_TMO_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_tmo_o |-> !done_o && !busy_o)); // R7
  AST_LEN_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_len_o |-> !busy_o && !$past(busy_o))); // R8
  AST_NO_READ_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (go_o && (st == SQ_ADDR || st == SQ_DATA) |-> op_o == OP_WR)); // R4
endmodule

// File: rtl/bsw_page_writer.sv
module bsw_page_writer
  import bsw_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 6,
  parameter int MAX_BYTES = 32,
  parameter int MAX_POLLS = 64,
  parameter int STROBE_W  = 2,
  parameter int GAP_W     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              wr_valid_i,
  input  logic [7:0]        wr_data_i,
  output logic              wr_ready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_len_o,
  output logic              err_tmo_o,
  output logic              mem_rst_o,
  output logic              mem_ce_n_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic              mem_io_o,
  output logic              mem_io_oe_o,
  input  logic              mem_io_i
);
  logic    go, cyc_bit, eng_idle, eng_done, eng_rbit;
  bus_op_e cyc_op;

  bsw_frame_seq #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BYTES(MAX_BYTES), .MAX_POLLS(MAX_POLLS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .len_i(len_i),
    .wvalid_i(wr_valid_i), .wdata_i(wr_data_i), .wready_o(wr_ready_o),
    .busy_o(busy_o), .done_o(done_o), .err_len_o(err_len_o), .err_tmo_o(err_tmo_o),
    .go_o(go), .op_o(cyc_op), .bit_o(cyc_bit),
    .eng_idle_i(eng_idle), .eng_done_i(eng_done), .eng_rbit_i(eng_rbit)
  );

  bsw_bus_cycle #(.STROBE_W(STROBE_W), .GAP_W(GAP_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .go_i(go), .op_i(cyc_op), .bit_i(cyc_bit),
    .idle_o(eng_idle), .done_o(eng_done), .rbit_o(eng_rbit),
    .ce_n_o(mem_ce_n_o), .oe_n_o(mem_oe_n_o), .we_n_o(mem_we_n_o),
    .io_o(mem_io_o), .io_oe_o(mem_io_oe_o), .pulse_o(mem_rst_o), .io_i(mem_io_i)
  );

  AST_WR_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n_o |-> !mem_ce_n_o && mem_oe_n_o && mem_io_oe_o)); // R1
  AST_RD_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n_o |-> !mem_ce_n_o && mem_we_n_o && !mem_io_oe_o)); // R1
  AST_WR_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n_o && $past(!mem_we_n_o) |-> $stable(mem_io_o))); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o |-> mem_ce_n_o && !mem_rst_o)); // R8
endmodule

// File: tb/bsw_page_writer_test.sv
module bsw_page_writer_test;
  localparam int CLK_PERIOD = 10;
  localparam int STROBE_W   = 3;
  localparam int GAP_W      = 2;
  localparam int MAX_POLLS  = 6;
  localparam int MAX_BYTES  = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, wvalid = 1'b0, io_in = 1'b0;
  logic [15:0] addr = '0;
  logic [5:0]  len = '0;
  logic [7:0]  wdata = '0;
  logic wready, busy, done, err_len, err_tmo;
  logic mrst, ce_n, oe_n, we_n, io_out, io_oe;

  bsw_page_writer #(.MAX_POLLS(MAX_POLLS), .STROBE_W(STROBE_W), .GAP_W(GAP_W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr), .len_i(len),
    .wr_valid_i(wvalid), .wr_data_i(wdata), .wr_ready_o(wready),
    .busy_o(busy), .done_o(done), .err_len_o(err_len), .err_tmo_o(err_tmo),
    .mem_rst_o(mrst), .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n), .mem_we_n_o(we_n),
    .mem_io_o(io_out), .mem_io_oe_o(io_oe), .mem_io_i(io_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bus monitor / memory model: kinds 0 write, 1 read, 2 reset pulse
  int rec_kind[0:639];
  int rec_bit[0:639];
  int rec_w[0:639];
  int rec_gap[0:639];
  int nrec = 0, lowc = 0, highc = 0, rd_seen = 0, r1_bad = 0, poll_low = 0;
  int cur_kind = 0, cur_bit = 0;
  bit in_cyc = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ce_n || mrst) begin
        if (!in_cyc) rec_gap[nrec] = highc;
        in_cyc = 1;
        lowc++;
        cur_kind = !we_n ? 0 : (!oe_n ? 1 : (mrst ? 2 : 3));
        cur_bit  = int'(io_out);
        if (!we_n && (!oe_n || !io_oe)) r1_bad++;
        if (!oe_n && io_oe) r1_bad++;
        if (mrst && !ce_n) r1_bad++;
      end else if (in_cyc) begin
        if (nrec < 640) begin
          rec_kind[nrec] = cur_kind;
          rec_bit[nrec]  = cur_bit;
          rec_w[nrec]    = lowc;
          nrec++;
        end
        if (cur_kind == 1) rd_seen++;
        in_cyc = 0;
        lowc = 0;
        highc = 1;
      end else begin
        highc++;
      end
      io_in = (rd_seen >= 2 + poll_low);
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  logic [7:0] bytes_q[0:31];

  // expected record i of a request: kind and bit
  function automatic void exp_rec(input int i, input logic [15:0] a, input int n,
                                  output int k, output int b);
    int d;
    d = i - 17;
    b = -1;
    if (i == 0) k = 2;
    else if (i <= 16) begin k = 0; b = int'(a[16-i]); end
    else if (d < 8*n) begin k = 0; b = int'(bytes_q[d/8][7 - d%8]); end
    else if (d == 8*n) k = 1;
    else if (d == 8*n + 1) begin k = 0; b = 1; end
    else k = 1;
  endfunction

  task automatic feed(input int n, input logic [15:0] a);
    @(negedge clk);
    start = 1'b1; addr = ~a; len = 6'd1;   // R9 stray start while busy
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      repeat ($urandom_range(0, 3)) @(negedge clk);
      wvalid = 1'b1; wdata = bytes_q[i];
      forever begin
        @(negedge clk);
        if (wready) break;
      end
      @(posedge clk);
      #1 wvalid = 1'b0;
    end
  endtask

  task automatic run_txn(input logic [15:0] a, input int n, input int pl);
    bit got_done, got_tmo, exp_tmo, seq_ok, ok_w;
    int npolls, nexp, k, b, bad_at;
    got_done = 0; got_tmo = 0;
    for (int i = 0; i < 32; i++) bytes_q[i] = 8'($urandom);
    @(negedge clk);
    nrec = 0; rd_seen = 0; poll_low = pl; highc = 0;
    start = 1'b1; addr = a; len = 6'(n);
    @(negedge clk);
    start = 1'b0;
    fork
      feed(n, a);
      begin
        for (int t = 0; t < 20000; t++) begin
          @(negedge clk);
          if (done || err_tmo) begin
            got_done = done; got_tmo = err_tmo;
            chk(!busy, "R6 busy low at end", int'(busy), 0);
            break;
          end
        end
      end
    join
    exp_tmo = (pl >= MAX_POLLS);
    npolls  = exp_tmo ? MAX_POLLS : pl + 1;
    nexp    = 1 + 16 + 8*n + 3 + npolls;
    if (exp_tmo) chk(got_tmo && !got_done, "R7 timeout flag", int'(got_tmo), 1);
    else chk(got_done && !got_tmo, "R6 done flag", int'(got_done), 1);
    chk(nrec == nexp, "R9 cycle count", nrec, nexp);
    // R3 reset + address, R4 data, R5 commit, R6 polls
    seq_ok = 1; bad_at = -1;
    for (int i = 0; i < nrec && i < nexp; i++) begin
      exp_rec(i, a, n, k, b);
      if (rec_kind[i] != k || (b >= 0 && rec_bit[i] != b)) begin
        if (seq_ok) bad_at = i;
        seq_ok = 0;
      end
    end
    chk(seq_ok, "R3 R4 R5 R6 bus trace mismatch index", bad_at, -1);
    ok_w = 1;
    for (int i = 0; i < nrec; i++) begin
      if (rec_w[i] != STROBE_W) ok_w = 0;
      if (i > 0 && rec_gap[i] < GAP_W) ok_w = 0;
    end
    chk(ok_w, "R2 strobe width and gap", int'(ok_w), 1);
    chk(r1_bad == 0, "R1 strobe combination", r1_bad, 0);
    repeat (3) @(negedge clk);
    chk(!done && !err_tmo, "R6 single pulse", int'(done | err_tmo), 0);
  endtask

  task automatic bad_len(input int n);
    @(negedge clk);
    nrec = 0;
    start = 1'b1; len = 6'(n); addr = 16'h1234;
    @(negedge clk);
    start = 1'b0;
    chk(err_len == 1'b1, "R8 err_len pulse", int'(err_len), 1);
    chk(busy == 1'b0, "R8 stays idle", int'(busy), 0);
    repeat (30) @(negedge clk);
    chk(nrec == 0 && !in_cyc, "R8 no bus cycles", nrec, 0);
    chk(err_len == 1'b0, "R8 pulse one clock", int'(err_len), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(ce_n && we_n && oe_n && !mrst, "R10 strobes idle in reset", {ce_n, we_n, oe_n, mrst}, 4'b1110);
    chk(!busy && !wready, "R10 busy/ready low in reset", {busy, wready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ce_n && !busy && !wready, "R10 idle after reset", {ce_n, busy, wready}, 3'b100);
    bad_len(0);
    bad_len(33);
    bad_len(63);
    run_txn(16'h8001, 1, 0);
    run_txn(16'hA5C3, MAX_BYTES, 2);
    run_txn(16'h0F0F, 3, MAX_POLLS - 1);
    run_txn(16'h7E00, 2, MAX_POLLS);
    run_txn(16'hFFFF, 5, MAX_POLLS + 3);
    for (int r = 0; r < 6; r++)
      run_txn(16'($urandom), $urandom_range(1, MAX_BYTES), $urandom_range(0, 3));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule